// File: doc/BRIEF.md
# Locked Read-Modify-Write Sequencer

This block performs atomic read-modify-write operations on a shared bus that carries an active-low, open-drain lock line. Any agent on the bus may pull the line low. A requester hands over an address, a modify function and an operand. The sequencer first waits until no other agent holds the lock. It then issues a locked read through a bus-master request port and computes the new value from the returned word. Finally it issues the write and hands the original read value back to the requester.

The block also runs locked interrupt-acknowledge cycles. Each is a single read with an acknowledge qualifier, and the lock is held from its address state until it completes. The lock output is a drive enable: low means "pull the line low". The resolved level of the line comes back on a separate sampled input. A bus cycle's address state is the single cycle in which `bus_start` is high. The bus reports completion with a one-cycle `bus_done` pulse.

Top module: `rmw_lock_seq`

## Requirements
- R1: While reset is active and after it is released, `req_ready` is 1, `lock_drive_n` is 1, and `bus_start` and `done` are 0.
- R2: After a request is accepted, the block samples `lock_in_n` once per cycle. While the line reads low, no bus cycle starts and `lock_drive_n` stays 1. On the cycle after the line is first sampled high, the first address state begins.
- R3: The read's address state has `bus_start`=1, `bus_write`=0, `bus_iack`=0, `bus_addr` equal to the request address and `lock_drive_n`=0.
- R4: `lock_drive_n` stays 0 from the read's address state until the write's address state. In the write's address state `lock_drive_n` is 1, with `bus_start`=1 and `bus_write`=1 at the same address.
- R5: The write data is computed from the read value R and the operand B according to `req_op`: 2'b00 gives R+B modulo 2^32, 2'b01 gives R AND B, 2'b10 gives R OR B, and 2'b11 gives B (exchange).
- R6: No further bus cycle starts while the block waits for the read's `bus_done`. Each address state lasts exactly one cycle.
- R7: One cycle after the edge that samples the write's `bus_done`, `done` is 1 for exactly one cycle. At that point `done_data` holds the original read value and `req_ready` is 1.
- R8: A request with `req_iack`=1 runs a single read with `bus_iack`=1 and `lock_drive_n`=0 from its address state until completion. On the `done` cycle `lock_drive_n` is back at 1 and `done_data` holds the returned word.
- R9: A `req_valid` raised while `req_ready` is 0 is ignored. The running operation keeps its address and data, and once it finishes no further bus cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_iack | input | 1 | 1 selects a locked interrupt-acknowledge cycle |
| req_op | input | 2 | Modify function (see R5) |
| req_addr | input | AW | Target address |
| req_operand | input | DW | Operand of the modify function |
| req_ready | output | 1 | Block is idle and accepts a request |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | DW | Original read value (or acknowledge word) |
| bus_start | output | 1 | Address state of a bus cycle |
| bus_write | output | 1 | Current bus cycle is a write |
| bus_iack | output | 1 | Current bus cycle is an interrupt acknowledge |
| bus_addr | output | AW | Bus cycle address |
| bus_wdata | output | DW | Write data |
| bus_done | input | 1 | Bus cycle completion pulse |
| bus_rdata | input | DW | Read data, valid with `bus_done` |
| lock_drive_n | output | 1 | Active-low drive enable for the lock line |
| lock_in_n | input | 1 | Sampled level of the lock line (1 = free) |

## Verification
A sequencer state that is out of step with the bus would show up within one cycle at the lock drive. The drive could fall while the line was already held, stay low into the write's address state, or let go during the read. A corrupt modify path shows up in the write's address state as a wrong `bus_wdata`. A lost capture of the read word shows up on the `done` cycle as a wrong `done_data`. Waiting phases of several cycles, injected both before the lock is free and before each completion, expose any premature address state in the first cycle it would occur.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_AND  = 2'b01,
    OP_OR   = 2'b10,
    OP_XCHG = 2'b11
  } rmw_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_RD_ADDR,
    S_RD_WAIT,
    S_WR_ADDR,
    S_WR_WAIT,
    S_IA_ADDR,
    S_IA_WAIT
  } seq_state_e;
endpackage

// File: rtl/rmw_rst_sync.sv
module rmw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu #(
  parameter int DW = 32
) (
  input  rmw_pkg::rmw_op_e op,
  input  logic [DW-1:0]    rd_val,
  input  logic [DW-1:0]    operand,
  output logic [DW-1:0]    result
);
  import rmw_pkg::*;

  always_comb begin
    case (op)
      OP_ADD:  result = rd_val + operand;
      OP_AND:  result = rd_val & operand;
      OP_OR:   result = rd_val | operand;
      default: result = operand;
    endcase
  end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_iack,
  input  logic bus_done,
  input  logic lock_in_n,
  output logic accept,
  output logic read_done,
  output logic finish,
  output logic req_ready,
  output logic bus_start,
  output logic bus_write,
  output logic bus_iack,
  output logic lock_drive_n
);
  import rmw_pkg::*;

  seq_state_e state_q, state_d;
  logic       iack_q;

  always_comb begin
    state_d   = state_q;
    accept    = 1'b0;
    read_done = 1'b0;
    finish    = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid) begin
        accept  = 1'b1;
        state_d = S_CHECK;
      end
      S_CHECK:   if (lock_in_n) state_d = iack_q ? S_IA_ADDR : S_RD_ADDR;
      S_RD_ADDR: state_d = S_RD_WAIT;
      S_RD_WAIT: if (bus_done) begin
        read_done = 1'b1;
        state_d   = S_WR_ADDR;
      end
      S_WR_ADDR: state_d = S_WR_WAIT;
      S_WR_WAIT: if (bus_done) begin
        finish  = 1'b1;
        state_d = S_IDLE;
      end
      S_IA_ADDR: state_d = S_IA_WAIT;
      S_IA_WAIT: if (bus_done) begin
        read_done = 1'b1;
        finish    = 1'b1;
        state_d   = S_IDLE;
      end
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      iack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) iack_q <= req_iack;
    end
  end

  always_comb begin
    req_ready    = (state_q == S_IDLE);
    bus_start    = (state_q == S_RD_ADDR) || (state_q == S_WR_ADDR) || (state_q == S_IA_ADDR);
    bus_write    = (state_q == S_WR_ADDR) || (state_q == S_WR_WAIT);
    bus_iack     = (state_q == S_IA_ADDR) || (state_q == S_IA_WAIT);
    lock_drive_n = !((state_q == S_RD_ADDR) || (state_q == S_RD_WAIT) ||
                     (state_q == S_IA_ADDR) || (state_q == S_IA_WAIT));
  end
endmodule

// File: rtl/rmw_lock_seq.sv
module rmw_lock_seq #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_iack,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_operand,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] done_data,
  output logic          bus_start,
  output logic          bus_write,
  output logic          bus_iack,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_done,
  input  logic [DW-1:0] bus_rdata,
  output logic          lock_drive_n,
  input  logic          lock_in_n
);
  import rmw_pkg::*;

  logic            srst_n;
  logic            accept, read_done, finish;
  logic [AW-1:0]   addr_q;
  rmw_op_e         op_q;
  logic [DW-1:0]   operand_q, wdata_q, rdata_q, alu_y;
  logic            done_q;

  rmw_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rmw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (srst_n),
    .req_valid    (req_valid),
    .req_iack     (req_iack),
    .bus_done     (bus_done),
    .lock_in_n    (lock_in_n),
    .accept       (accept),
    .read_done    (read_done),
    .finish       (finish),
    .req_ready    (req_ready),
    .bus_start    (bus_start),
    .bus_write    (bus_write),
    .bus_iack     (bus_iack),
    .lock_drive_n (lock_drive_n)
  );

  rmw_alu #(.DW(DW)) u_alu (
    .op      (op_q),
    .rd_val  (bus_rdata),
    .operand (operand_q),
    .result  (alu_y)
  );

  // Datapath: request fields on accept, read word and modified word on read completion
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q    <= req_addr;
      op_q      <= rmw_op_e'(req_op);
      operand_q <= req_operand;
    end
    if (read_done) begin
      rdata_q <= bus_rdata;
      wdata_q <= alu_y;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) done_q <= 1'b0;
    else         done_q <= finish;
  end

  assign done      = done_q;
  assign done_data = rdata_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
endmodule

// File: rtl/rmw_lock_seq_chk.sv
module rmw_lock_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic bus_start,
  input logic bus_write,
  input logic bus_iack,
  input logic lock_drive_n,
  input logic lock_in_n
);
  // R2
  claim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_drive_n) |-> $past(lock_in_n));
  // R3
  rd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !bus_write) |-> !lock_drive_n);
  // R4
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && bus_write) |-> lock_drive_n);
  // R6
  one_cycle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && lock_drive_n));
  // R8
  iack_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_iack |-> !lock_drive_n);
endmodule

bind rmw_lock_seq rmw_lock_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .done         (done),
  .bus_start    (bus_start),
  .bus_write    (bus_write),
  .bus_iack     (bus_iack),
  .lock_drive_n (lock_drive_n),
  .lock_in_n    (lock_in_n)
);

// File: tb/rmw_lock_seq_tb.sv
`timescale 1ns/1ps
module rmw_lock_seq_tb;
  localparam int DW = 32;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_iack = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_operand = '0;
  logic          req_ready, done, bus_start, bus_write, bus_iack, lock_drive_n;
  logic [DW-1:0] done_data, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic          bus_done = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          ext_free = 1'b1;
  logic          lock_in_n;
  int            n_chk = 0, n_fail = 0;
  bit            finished = 1'b0;

  // Wired-AND of the open-drain line: low if either agent drives it
  assign lock_in_n = lock_drive_n & ext_free;

  always #5 clk = ~clk;

  rmw_lock_seq #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_iack(req_iack),
    .req_op(req_op), .req_addr(req_addr), .req_operand(req_operand),
    .req_ready(req_ready), .done(done), .done_data(done_data),
    .bus_start(bus_start), .bus_write(bus_write), .bus_iack(bus_iack),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
    .bus_rdata(bus_rdata), .lock_drive_n(lock_drive_n), .lock_in_n(lock_in_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // iack, op, addr, operand, read word, cycles lock held by another agent, expected write word
  typedef struct packed {
    logic        iack;
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] operand;
    logic [31:0] rdata;
    logic [3:0]  hold;
    logic [31:0] exp_w;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 2'b00, 32'h0000_0100, 32'h0000_0005, 32'h0000_000A, 4'd0, 32'h0000_000F},
    '{1'b0, 2'b00, 32'h0000_0104, 32'h0000_0002, 32'hFFFF_FFFF, 4'd2, 32'h0000_0001},
    '{1'b0, 2'b01, 32'h0000_0200, 32'h0F0F_00FF, 32'h1234_5678, 4'd0, 32'h0204_0078},
    '{1'b0, 2'b10, 32'h0000_0300, 32'hA000_0001, 32'h0000_F000, 4'd1, 32'hA000_F001},
    '{1'b0, 2'b11, 32'h0000_0400, 32'hCAFE_F00D, 32'h1111_1111, 4'd3, 32'hCAFE_F00D},
    '{1'b1, 2'b00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0040, 4'd1, 32'h0000_0000}
  };

  task automatic run_vec(input vec_t v, input bit poke_busy);
    @(negedge clk);
    req_valid = 1'b1; req_iack = v.iack; req_op = v.op;
    req_addr = v.addr; req_operand = v.operand;
    ext_free = (v.hold == 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 accepted, waiting", {req_ready, bus_start, lock_drive_n}, {1'b0, 1'b0, 1'b1});
    for (int i = 0; i < int'(v.hold); i++) begin
      @(negedge clk);
      chk("R2 lock held, no start", {bus_start, lock_drive_n}, {1'b0, 1'b1});
    end
    ext_free = 1'b1;
    @(negedge clk);
    if (v.iack) begin
      chk("R8 iack address state", {bus_start, bus_write, bus_iack, lock_drive_n}, {1'b1, 1'b0, 1'b1, 1'b0});
    end else begin
      chk("R3 read address state", {bus_start, bus_write, bus_iack, lock_drive_n}, {1'b1, 1'b0, 1'b0, 1'b0});
      chk("R3 read address", bus_addr, v.addr);
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R6 wait for read, lock held", {bus_start, lock_drive_n}, {1'b0, 1'b0});
    end
    bus_done = 1'b1; bus_rdata = v.rdata;
    @(negedge clk);
    bus_done = 1'b0; bus_rdata = '0;
    if (!v.iack) begin
      chk("R4 write address state releases lock", {bus_start, bus_write, lock_drive_n}, {1'b1, 1'b1, 1'b1});
      chk("R4 write address", bus_addr, v.addr);
      chk("R5 write data", bus_wdata, v.exp_w);
      @(negedge clk);
      chk("R6 write wait", {bus_start, done}, {1'b0, 1'b0});
      if (poke_busy) begin
        req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_operand = 32'h1;
      end
      bus_done = 1'b1;
      @(negedge clk);
      bus_done = 1'b0; req_valid = 1'b0;
      chk("R7 done pulse", {done, req_ready}, {1'b1, 1'b1});
      chk("R7 original read value", done_data, v.rdata);
    end else begin
      chk("R8 done with lock released", {done, lock_drive_n, req_ready}, {1'b1, 1'b1, 1'b1});
      chk("R8 acknowledge word", done_data, v.rdata);
    end
    @(negedge clk);
    chk("R7 done lasts one cycle", done, 1'b0);
    if (poke_busy) begin
      @(negedge clk);
      chk("R9 busy request ignored", {req_ready, bus_start, lock_drive_n}, {1'b1, 1'b0, 1'b1});
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {req_ready, lock_drive_n, bus_start, done}, {1'b1, 1'b1, 1'b0, 1'b0});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", {req_ready, lock_drive_n, bus_start, done}, {1'b1, 1'b1, 1'b0, 1'b0});

    foreach (VECS[i]) run_vec(VECS[i], 1'b0);

    // R9: request raised while the write is outstanding
    run_vec(VECS[2], 1'b1);

    // R1: reset during a locked read drops the lock drive at once
    @(negedge clk);
    req_valid = 1'b1; req_iack = 1'b0; req_op = 2'b00; req_addr = 32'h10;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 locked before reset", lock_drive_n, 1'b0);
    #1 rst_n = 1'b0;
    #1 chk("R1 reset releases lock", {lock_drive_n, req_ready}, {1'b1, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {req_ready, bus_start, done}, {1'b1, 1'b0, 1'b0});

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule